// File: doc/BRIEF.md
# DMA Channel Error Status Capture

This block collects fault reports from the channels of a 64-channel DMA engine. Each fault reaches the block as a one-cycle pulse. The pulse carries the number of the failing channel and a set of cause bits. The block keeps one error flag per channel and a summary word that holds the first fault seen since the flags were last all clear. It also drives an error interrupt for the channels whose error interrupt is enabled.

Software reaches the block through a simple word-indexed register port. It reads the summary word, the two halves of the flag vector and the two halves of the enable vector. Three byte-style command registers take a channel number in the low bits of the write data. They clear that channel's flag, set its enable or clear its enable. A whole flag word can also be cleared by writing ones to it, one bit per flag.

Top module: `dma_err_capture`

## Requirements
- R1: After reset every readable register reads 0 and `err_irq_o` is 0.
- R2: A fault pulse on channel c sets flag c on the next clock edge. Flags for channels 63..32 appear in the high flag word (index 1, bit c-32). Flags for channels 31..0 appear in the low flag word (index 2, bit c).
- R3: A fault that arrives while no other flag stays set is captured in the summary word (index 0). The word has bit 31 = 1, bits 13:8 = channel number, and bits 15, 14 and 7:0 = the matching cause input bits. Cause input bits 13:8 are dropped. Every other summary bit reads 0.
- R4: While some other flag remains set, a later fault changes only its own flag and leaves the summary word unchanged.
- R5: A write of channel number c to the clear-flag command (index 5, data bits 5:0) clears only flag c.
- R6: A write to a flag word (index 1 or 2) clears each flag whose data bit is 1. A write of all ones clears the whole word.
- R7: Once no flag is set, the summary word reads 0.
- R8: A write of c to the set-enable command (index 6) or the clear-enable command (index 7) sets or clears enable c. The enable words read at index 3 (channels 63..32) and index 4 (channels 31..0).
- R9: `err_irq_o` is 1 exactly when some channel has both its flag and its enable set.
- R10: When a fault on channel c and a clear of flag c fall in the same cycle, flag c ends up set.
- R11: When a fault arrives in the same cycle that clears the last remaining flags, the new fault becomes the summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vld_i | input | 1 | One-cycle fault report strobe |
| fault_ch_i | input | 6 | Channel number of the fault |
| fault_cause_i | input | 16 | Cause bits, placed as in the summary word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_idx_i` (combinational) |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The hardest cases to reach are the ones where a fault and a register write act on the same state in the same cycle. One is a fault on a channel together with a clear of that same channel. The other is a fault together with the clear that removes the last surviving flag, which decides whether the summary is replaced. The bench drives the fault strobe and the register write on the same clock edge from one task. It then reads back the flag word and the summary word to see which side won.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int CAUSE_W = 16;
  localparam logic [CAUSE_W-1:0] CAUSE_KEEP = 16'hC0FF;

  typedef enum logic [IDX_W-1:0] {
    IDX_SUMMARY  = 4'd0,
    IDX_FLAG_HI  = 4'd1,
    IDX_FLAG_LO  = 4'd2,
    IDX_EN_HI    = 4'd3,
    IDX_EN_LO    = 4'd4,
    IDX_CLR_FLAG = 4'd5,
    IDX_SET_EN   = 4'd6,
    IDX_CLR_EN   = 4'd7
  } reg_idx_e;
endpackage

// File: rtl/err_flag_bank.sv
module err_flag_bank #(
  parameter int CHAN_W = 6,
  localparam int NCH = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [CHAN_W-1:0] set_ch_i,
  input  logic              clr_one_i,
  input  logic [CHAN_W-1:0] clr_ch_i,
  input  logic [NCH-1:0]    clr_mask_i,
  output logic [NCH-1:0]    flags_o,
  output logic              others_o,
  output logic              any_next_o
);
  logic [NCH-1:0] flags_q, flags_d, clr_vec, set_vec, kept;

  always_comb begin
    clr_vec = clr_mask_i;
    if (clr_one_i) clr_vec[clr_ch_i] = 1'b1;
    set_vec = '0;
    if (set_i) set_vec[set_ch_i] = 1'b1;
    kept    = flags_q & ~clr_vec;
    flags_d = kept | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o    = flags_q;
  assign others_o   = |kept;
  assign any_next_o = |flags_d;

  // R2 R10
  fault_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flags_q[$past(set_ch_i)]);
  // R5
  byte_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_one_i && !(set_i && set_ch_i == clr_ch_i)) |=> !flags_q[$past(clr_ch_i)]);
endmodule

// File: rtl/err_enable_bank.sv
module err_enable_bank #(
  parameter int CHAN_W = 6,
  localparam int NCH = 1 << CHAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [CHAN_W-1:0] ch_i,
  output logic [NCH-1:0]    en_o
);
  logic [NCH-1:0] en_q, en_d, hit;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit[g] = (ch_i == CHAN_W'(g));
    always_comb begin
      en_d[g] = en_q[g];
      if (hit[g] && set_i)      en_d[g] = 1'b1;
      else if (hit[g] && clr_i) en_d[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign en_o = en_q;

  // R8
  set_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> en_q[$past(ch_i)]);
  // R8
  clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !en_q[$past(ch_i)]);
endmodule

// File: rtl/err_summary.sv
module err_summary
  import dec_pkg::*;
#(
  parameter int CHAN_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic [CHAN_W-1:0]  ch_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               others_i,
  input  logic               any_next_i,
  output logic               valid_o,
  output logic [DATA_W-1:0]  word_o
);
  logic               valid_q;
  logic [CHAN_W-1:0]  ch_q, ch_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               take;

  always_comb begin
    take    = fault_i && !others_i;
    ch_d    = ch_q;
    cause_d = cause_q;
    if (take) begin
      ch_d    = ch_i;
      cause_d = cause_i & CAUSE_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ch_q    <= '0;
      cause_q <= '0;
    end else begin
      valid_q <= any_next_i;
      if (take) begin
        ch_q    <= ch_d;
        cause_q <= cause_d;
      end
    end
  end

  always_comb begin
    word_o = '0;
    if (valid_q) begin
      word_o[31]          = 1'b1;
      word_o[15:14]       = cause_q[15:14];
      word_o[8 +: CHAN_W] = ch_q;
      word_o[7:0]         = cause_q[7:0];
    end
  end

  assign valid_o = valid_q;

  // R3 R11
  first_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && !others_i) |=> (valid_q && ch_q == $past(ch_i)));
  // R4
  summary_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && others_i) |=> (valid_q && $stable(ch_q) && $stable(cause_q)));
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dec_pkg::*;
#(
  parameter int CHAN_W = 6,
  localparam int NCH   = 1 << CHAN_W,
  localparam int NWORD = NCH / DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_vld_i,
  input  logic [CHAN_W-1:0]  fault_ch_i,
  input  logic [CAUSE_W-1:0] fault_cause_i,
  input  logic               reg_wr_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               err_irq_o
);
  logic [NCH-1:0]    flags, en, clr_mask;
  logic [DATA_W-1:0] flag_w [NWORD];
  logic [DATA_W-1:0] en_w   [NWORD];
  logic [DATA_W-1:0] sum_word;
  logic              others, any_next, sum_valid;
  logic              wr_clr_flag, wr_set_en, wr_clr_en, wr_flag_hi, wr_flag_lo;
  logic [CHAN_W-1:0] cmd_ch;

  assign cmd_ch      = reg_wdata_i[CHAN_W-1:0];
  assign wr_clr_flag = reg_wr_i && (reg_idx_i == IDX_CLR_FLAG);
  assign wr_set_en   = reg_wr_i && (reg_idx_i == IDX_SET_EN);
  assign wr_clr_en   = reg_wr_i && (reg_idx_i == IDX_CLR_EN);
  assign wr_flag_hi  = reg_wr_i && (reg_idx_i == IDX_FLAG_HI);
  assign wr_flag_lo  = reg_wr_i && (reg_idx_i == IDX_FLAG_LO);

  for (genvar w = 0; w < NWORD; w++) begin : g_word
    assign flag_w[w] = flags[w*DATA_W +: DATA_W];
    assign en_w[w]   = en[w*DATA_W +: DATA_W];
    if (w == NWORD - 1) begin : g_hi
      assign clr_mask[w*DATA_W +: DATA_W] = wr_flag_hi ? reg_wdata_i : '0;
    end else begin : g_lo
      assign clr_mask[w*DATA_W +: DATA_W] = (wr_flag_lo && w == 0) ? reg_wdata_i : '0;
    end
  end

  err_flag_bank #(.CHAN_W(CHAN_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (fault_vld_i),
    .set_ch_i   (fault_ch_i),
    .clr_one_i  (wr_clr_flag),
    .clr_ch_i   (cmd_ch),
    .clr_mask_i (clr_mask),
    .flags_o    (flags),
    .others_o   (others),
    .any_next_o (any_next)
  );

  err_enable_bank #(.CHAN_W(CHAN_W)) u_enables (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_set_en),
    .clr_i (wr_clr_en),
    .ch_i  (cmd_ch),
    .en_o  (en)
  );

  err_summary #(.CHAN_W(CHAN_W)) u_summary (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault_vld_i),
    .ch_i       (fault_ch_i),
    .cause_i    (fault_cause_i),
    .others_i   (others),
    .any_next_i (any_next),
    .valid_o    (sum_valid),
    .word_o     (sum_word)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      IDX_SUMMARY: reg_rdata_o = sum_word;
      IDX_FLAG_HI: reg_rdata_o = flag_w[NWORD-1];
      IDX_FLAG_LO: reg_rdata_o = flag_w[0];
      IDX_EN_HI:   reg_rdata_o = en_w[NWORD-1];
      IDX_EN_LO:   reg_rdata_o = en_w[0];
      default:     reg_rdata_o = '0;
    endcase
  end

  assign err_irq_o = |(flags & en);

  // R7
  valid_tracks_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid == (|flags));
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !err_irq_o);
endmodule

// File: tb/dma_err_capture_bench.sv
module dma_err_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_vld_i = 1'b0;
  logic [5:0]  fault_ch_i = '0;
  logic [15:0] fault_cause_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        err_irq_o;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dma_err_capture u_dma_err_capture (
    .clk(clk), .rst_n(rst_n), .fault_vld_i(fault_vld_i), .fault_ch_i(fault_ch_i),
    .fault_cause_i(fault_cause_i), .reg_wr_i(reg_wr_i), .reg_idx_i(reg_idx_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .err_irq_o(err_irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] idx, input logic [31:0] exp);
    reg_idx_i = idx;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  // one clock edge with optional fault and optional write
  task automatic step(input logic f, input logic [5:0] ch, input logic [15:0] cause,
                      input logic w, input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    fault_vld_i = f; fault_ch_i = ch; fault_cause_i = cause;
    reg_wr_i = w; reg_idx_i = idx; reg_wdata_i = data;
    @(negedge clk);
    fault_vld_i = 1'b0; reg_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 5; i++) rd_chk("R1 reset read", 4'(i), 32'h0);
    check("R1 reset irq", {31'b0, err_irq_o}, 32'h0);
  endtask

  task automatic t_first_error;
    step(1, 6'd5, 16'h0080, 0, 0, 0);
    rd_chk("R3 summary first", 4'd0, 32'h8000_0580);
    rd_chk("R2 low word", 4'd2, 32'h0000_0020);
    rd_chk("R2 high word", 4'd1, 32'h0);
    check("R9 irq off without enable", {31'b0, err_irq_o}, 32'h0);
  endtask

  task automatic t_second_error;
    step(1, 6'd40, 16'h0001, 0, 0, 0);
    rd_chk("R4 summary kept", 4'd0, 32'h8000_0580);
    rd_chk("R2 high word ch40", 4'd1, 32'h0000_0100);
  endtask

  task automatic t_enable;
    step(0, 0, 0, 1, 4'd6, 32'h0000_0028);
    rd_chk("R8 enable high", 4'd3, 32'h0000_0100);
    check("R9 irq on", {31'b0, err_irq_o}, 32'h1);
    step(0, 0, 0, 1, 4'd7, 32'h0000_0028);
    rd_chk("R8 enable cleared", 4'd3, 32'h0);
    check("R9 irq off", {31'b0, err_irq_o}, 32'h0);
  endtask

  task automatic t_byte_clear;
    step(0, 0, 0, 1, 4'd5, 32'h0000_0005);
    rd_chk("R5 low cleared", 4'd2, 32'h0);
    rd_chk("R5 high untouched", 4'd1, 32'h0000_0100);
    rd_chk("R4 summary while flag left", 4'd0, 32'h8000_0580);
    step(0, 0, 0, 1, 4'd5, 32'h0000_0028);
    rd_chk("R5 high cleared", 4'd1, 32'h0);
    rd_chk("R7 summary zero", 4'd0, 32'h0);
  endtask

  task automatic t_mask_and_word_clear;
    step(1, 6'd63, 16'h3F3C, 0, 0, 0);
    rd_chk("R3 cause mask", 4'd0, 32'h8000_3F3C);
    rd_chk("R2 ch63", 4'd1, 32'h8000_0000);
    step(0, 0, 0, 1, 4'd1, 32'hFFFF_FFFF);
    rd_chk("R6 word clear", 4'd1, 32'h0);
    rd_chk("R7 after word clear", 4'd0, 32'h0);
  endtask

  task automatic t_collision;
    step(1, 6'd3, 16'h0008, 1, 4'd5, 32'h0000_0003);
    rd_chk("R10 set wins", 4'd2, 32'h0000_0008);
    rd_chk("R10 summary", 4'd0, 32'h8000_0308);
  endtask

  task automatic t_refresh;
    step(1, 6'd9, 16'h4000, 1, 4'd5, 32'h0000_0003);
    rd_chk("R11 flags", 4'd2, 32'h0000_0200);
    rd_chk("R11 new summary", 4'd0, 32'h8000_4900);
  endtask

  task automatic t_partial_w1c;
    step(0, 0, 0, 1, 4'd6, 32'h0000_0009);
    step(0, 0, 0, 1, 4'd6, 32'h0000_0003);
    rd_chk("R8 enable low", 4'd4, 32'h0000_0208);
    check("R9 irq low ch", {31'b0, err_irq_o}, 32'h1);
    step(1, 6'd10, 16'h0002, 0, 0, 0);
    rd_chk("R2 ch10", 4'd2, 32'h0000_0600);
    step(0, 0, 0, 1, 4'd2, 32'h0000_0200);
    rd_chk("R6 partial clear", 4'd2, 32'h0000_0400);
    rd_chk("R4 first kept", 4'd0, 32'h8000_4900);
    check("R9 irq unmatched", {31'b0, err_irq_o}, 32'h0);
    step(0, 0, 0, 1, 4'd2, 32'hFFFF_FFFF);
    rd_chk("R7 final", 4'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_error();
    t_second_error();
    t_enable();
    t_byte_clear();
    t_mask_and_word_clear();
    t_collision();
    t_refresh();
    t_partial_w1c();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule